// File: doc/BRIEF.md
# Digital Frequency-Locked Loop Controller

This block closes a frequency-locked loop around a digitally controlled oscillator. It runs on the oscillator's own clock. A slow reference strobe arrives asynchronously and is synchronized into that clock domain. The block counts oscillator cycles between successive reference rising edges and compares the count with the target `N * 2^D`. After each comparison it nudges a 10-bit control word one step towards lock. The oscillator's average frequency therefore settles at the reference frequency times `N * 2^D`. As an example, a 32768 Hz reference with `D = 0, N = 610`, or with `D = 1, N = 305`, targets roughly 20 MHz.

The control word splits into two fields:
- The upper five bits select one of 32 coarse oscillator taps.
- The lower five bits give a fractional count out of 32.

A modulator turns that fraction into a per-cycle choice between the selected tap and the next higher tap. It spreads the higher-tap cycles across each 32-cycle frame. A three-bit range selection is passed unchanged to the oscillator. A divided clock enable ticks once every `2^D` oscillator cycles.

Top module: `fll_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the control word is 512, the limit flag is low, `tap_sel` is 16 and `div_tick` is low.
- R2: On a qualified reference edge, if the cycle count since the previous reference edge exceeds `N * 2^D`, the control word decreases by exactly one.
- R3: On a qualified reference edge, if the count is below `N * 2^D`, the control word increases by exactly one.
- R4: On a qualified reference edge, if the count equals `N * 2^D`, the control word is unchanged. The target scales with `2^D`, so `D = 1, N = 50` and `D = 0, N = 100` both target a count of 100.
- R5: The first reference edge after reset, and the first after `loop_en` returns high, only starts a measurement and never changes the control word.
- R6: The control word saturates at 1023 and at 0 instead of wrapping. `word_at_limit` is high exactly while the word sits at either value.
- R7: While `loop_en` is low, the control word holds its value whatever happens on the reference.
- R8: `tap_sel` takes one of two values each cycle: the tap field (word bits 9:5), or that field plus one. In any 32 consecutive cycles with a constant word, the plus-one value appears exactly as many times as the fraction field (word bits 4:0). At tap 31 the output stays at 31.
- R9: `div_tick` is high for exactly 64 / 2^D of any 64 consecutive cycles when D is 0 to 6. With D = 0 it is high every cycle.
- R10: `range_out` always equals `range_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference strobe |
| loop_en | input | 1 | Loop enable; low freezes the control word |
| mult_n | input | 10 | Frequency multiplier N |
| div_exp | input | 3 | Divider exponent D |
| range_in | input | 3 | Oscillator range selection from software |
| range_out | output | 3 | Range selection passed to the oscillator |
| ctrl_word | output | 10 | Control word: tap field in bits 9:5, fraction in bits 4:0 |
| tap_sel | output | 5 | Per-cycle dithered tap to the oscillator |
| word_at_limit | output | 1 | High while the control word is 0 or 1023 |
| div_tick | output | 1 | Divided clock enable, once every 2^D cycles |

## Verification
A wrong measurement counter or comparison shows up as a control word that moves in the wrong direction, or moves by the wrong amount. This becomes visible a few cycles after the synchronized reference edge that completes the measurement. A stale validity flag, after reset or after re-enabling, shows up as an extra step on the first edge. A faulty modulator phase or bit-reversal shows up within one 32-cycle window, as a wrong count of upper-tap cycles. A wrong divider mask shows up as the wrong number of ticks in a 64-cycle window.

// File: rtl/fll_pkg.sv
// Shared types for the frequency-locked loop controller.
// Assumes: nothing beyond the standard.
package fll_pkg;

    // Outcome of one period measurement against the target count
    typedef enum logic [1:0] {
        CMP_MATCH = 2'd0,
        CMP_SLOW  = 2'd1,
        CMP_FAST  = 2'd2
    } fll_cmp_e;

endpackage

// File: rtl/fll_sync_edge.sv
// Two-flop synchronizer followed by rising-edge detection.
// Assumes: async_in stays high for at least two clk cycles per pulse.
module fll_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] shreg;

    // shift the asynchronous input through two sync stages plus a history stage
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[1:0], async_in};
    end

    assign rise = shreg[1] & ~shreg[2];
endmodule

// File: rtl/fll_loop.sv
// Period measurement and control-word update. Counts clk cycles between
// synchronized reference edges, compares with N*2^D, steps the word by one.
// Assumes: ref_rise is a single-cycle pulse in the clk domain.
module fll_loop #(
    parameter int WORD_W = 10,
    parameter int N_W    = 10,
    parameter int D_W    = 3,
    parameter int CNT_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic              ref_rise,
    input  logic [N_W-1:0]    mult_n,
    input  logic [D_W-1:0]    div_exp,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              word_at_limit
);
    import fll_pkg::*;

    localparam logic [WORD_W-1:0] WORD_MAX = '1;
    localparam logic [WORD_W-1:0] WORD_MID = WORD_W'(1) << (WORD_W - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

    logic [CNT_W-1:0] cyc_cnt;
    logic [CNT_W:0]   measured;
    logic [CNT_W:0]   target;
    logic             meas_valid;
    fll_cmp_e         verdict;

    assign measured = (CNT_W+1)'(cyc_cnt) + (CNT_W+1)'(1);
    assign target   = (CNT_W+1)'(mult_n) << div_exp;

    // classify the finished period against the target
    always_comb begin
        if (measured < target)      verdict = CMP_SLOW;
        else if (measured > target) verdict = CMP_FAST;
        else                        verdict = CMP_MATCH;
    end

    // count cycles since the last reference edge, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                 cyc_cnt <= '0;
        else if (ref_rise)          cyc_cnt <= '0;
        else if (cyc_cnt != CNT_MAX) cyc_cnt <= cyc_cnt + CNT_W'(1);
    end

    // a measurement is valid only after an edge seen while enabled
    always_ff @(posedge clk) begin
        if (!rst_n || !loop_en) meas_valid <= 1'b0;
        else if (ref_rise)      meas_valid <= 1'b1;
    end

    // step the control word towards lock, saturating at both ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_word <= WORD_MID;
        end else if (loop_en && ref_rise && meas_valid) begin
            case (verdict)
                CMP_SLOW: if (ctrl_word != WORD_MAX) ctrl_word <= ctrl_word + WORD_W'(1);
                CMP_FAST: if (ctrl_word != '0)       ctrl_word <= ctrl_word - WORD_W'(1);
                default:  ctrl_word <= ctrl_word;
            endcase
        end
    end

    assign word_at_limit = (ctrl_word == '0) || (ctrl_word == WORD_MAX);
endmodule

// File: rtl/fll_modulator.sv
// Fractional tap dither: over each 2^FRAC_W frame it picks tap+1 for
// 'frac' cycles, spread by comparing frac with the bit-reversed phase.
// Assumes: the top tap cannot go higher and is clamped.
module fll_modulator #(
    parameter int TAP_W  = 5,
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAP_W-1:0]  tap,
    input  logic [FRAC_W-1:0] frac,
    output logic [TAP_W-1:0]  tap_sel
);
    localparam logic [TAP_W-1:0] TAP_MAX = '1;
    localparam logic [TAP_W-1:0] TAP_MID = TAP_W'(1) << (TAP_W - 1);

    logic [FRAC_W-1:0] phase;
    logic [FRAC_W-1:0] phase_rev;
    logic              go_up;

    for (genvar gi = 0; gi < FRAC_W; gi++) begin : g_rev
        assign phase_rev[gi] = phase[FRAC_W-1-gi];
    end

    assign go_up = (phase_rev < frac);

    // free-running frame phase
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + FRAC_W'(1);
    end

    // register the dithered tap, clamped at the top tap
    always_ff @(posedge clk) begin
        if (!rst_n)                       tap_sel <= TAP_MID;
        else if (go_up && tap != TAP_MAX) tap_sel <= tap + TAP_W'(1);
        else                              tap_sel <= tap;
    end
endmodule

// File: rtl/fll_divider.sv
// Divided clock enable: one tick every 2^div_exp cycles.
// Assumes: div_exp may change at any time; the tick realigns freely.
module fll_divider #(
    parameter int D_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [D_W-1:0] div_exp,
    output logic           div_tick
);
    localparam int CW = (1 << D_W) - 1;

    logic [CW-1:0] free_cnt;
    logic [CW-1:0] mask;

    assign mask = (CW'(1) << div_exp) - CW'(1);

    // free-running cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) free_cnt <= '0;
        else        free_cnt <= free_cnt + CW'(1);
    end

    // tick when the low D bits of the counter are all ones
    always_ff @(posedge clk) begin
        if (!rst_n) div_tick <= 1'b0;
        else        div_tick <= ((free_cnt & mask) == mask);
    end
endmodule

// File: rtl/fll_ctrl.sv
// Top of the frequency-locked loop controller: synchronizer, loop,
// modulator and divider on the oscillator clock.
// Assumes: clk is the oscillator output; ref_in is asynchronous and slow.
module fll_ctrl #(
    parameter int WORD_W  = 10,
    parameter int TAP_W   = 5,
    parameter int N_W     = 10,
    parameter int D_W     = 3,
    parameter int RANGE_W = 3,
    parameter int CNT_W   = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_in,
    input  logic               loop_en,
    input  logic [N_W-1:0]     mult_n,
    input  logic [D_W-1:0]     div_exp,
    input  logic [RANGE_W-1:0] range_in,
    output logic [RANGE_W-1:0] range_out,
    output logic [WORD_W-1:0]  ctrl_word,
    output logic [TAP_W-1:0]   tap_sel,
    output logic               word_at_limit,
    output logic               div_tick
);
    localparam int FRAC_W = WORD_W - TAP_W;

    logic ref_rise;

    fll_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_in),
        .rise     (ref_rise)
    );

    fll_loop #(
        .WORD_W (WORD_W),
        .N_W    (N_W),
        .D_W    (D_W),
        .CNT_W  (CNT_W)
    ) u_loop (
        .clk           (clk),
        .rst_n         (rst_n),
        .loop_en       (loop_en),
        .ref_rise      (ref_rise),
        .mult_n        (mult_n),
        .div_exp       (div_exp),
        .ctrl_word     (ctrl_word),
        .word_at_limit (word_at_limit)
    );

    fll_modulator #(
        .TAP_W  (TAP_W),
        .FRAC_W (FRAC_W)
    ) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap     (ctrl_word[WORD_W-1:FRAC_W]),
        .frac    (ctrl_word[FRAC_W-1:0]),
        .tap_sel (tap_sel)
    );

    fll_divider #(
        .D_W (D_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_exp  (div_exp),
        .div_tick (div_tick)
    );

    assign range_out = range_in;
endmodule

// File: rtl/fll_ctrl_chk.sv
// Temporal checks on the controller ports, bound into every fll_ctrl.
// Assumes: default field split of the top parameters.
module fll_ctrl_chk #(
    parameter int WORD_W = 10,
    parameter int TAP_W  = 5,
    parameter int D_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loop_en,
    input logic [D_W-1:0]    div_exp,
    input logic [WORD_W-1:0] ctrl_word,
    input logic [TAP_W-1:0]  tap_sel,
    input logic              div_tick
);
    localparam logic [WORD_W-1:0] WMAX = '1;
    localparam logic [TAP_W-1:0]  TMAX = '1;

    AST_WORD_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word == $past(ctrl_word)) || (ctrl_word == $past(ctrl_word) + WORD_W'(1))
        || (ctrl_word == $past(ctrl_word) - WORD_W'(1))); // R2

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> $stable(ctrl_word)); // R7

    AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_word) == WMAX) |-> (ctrl_word != '0)); // R6

    AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_word) == '0) |-> (ctrl_word != WMAX)); // R6

    AST_TAP_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_sel == $past(ctrl_word[WORD_W-1:WORD_W-TAP_W]))
        || (($past(ctrl_word[WORD_W-1:WORD_W-TAP_W]) != TMAX)
            && (tap_sel == $past(ctrl_word[WORD_W-1:WORD_W-TAP_W]) + TAP_W'(1)))); // R8

    AST_DIV_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(div_exp) == '0)) |-> div_tick); // R9
endmodule

bind fll_ctrl fll_ctrl_chk #(
    .WORD_W (WORD_W),
    .TAP_W  (TAP_W),
    .D_W    (D_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_en   (loop_en),
    .div_exp   (div_exp),
    .ctrl_word (ctrl_word),
    .tap_sel   (tap_sel),
    .div_tick  (div_tick)
);

// File: tb/tb_fll_ctrl.sv
// Directed bench for fll_ctrl: one task per scenario, each self-checking.
module tb_fll_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       loop_en = 1'b0;
    logic [9:0] mult_n = 10'd100;
    logic [2:0] div_exp = 3'd0;
    logic [2:0] range_in = 3'd0;
    logic [2:0] range_out;
    logic [9:0] ctrl_word;
    logic [4:0] tap_sel;
    logic       word_at_limit;
    logic       div_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    fll_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_in        (ref_in),
        .loop_en       (loop_en),
        .mult_n        (mult_n),
        .div_exp       (div_exp),
        .range_in      (range_in),
        .range_out     (range_out),
        .ctrl_word     (ctrl_word),
        .tap_sel       (tap_sel),
        .word_at_limit (word_at_limit),
        .div_tick      (div_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference pulses with a period of 'per' clk cycles
    task automatic send_edges(input int per, input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk) ref_in = 1'b1;
            repeat (2) @(negedge clk);
            ref_in = 1'b0;
            repeat (per - 3) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // drop and restore the enable so the next edge only starts a measurement
    task automatic rearm();
        @(negedge clk) loop_en = 1'b0;
        repeat (2) @(negedge clk);
        loop_en = 1'b1;
    endtask

    // count upper-tap cycles over 32 consecutive cycles
    task automatic check_dither(input string req);
        int up = 0;
        int base = 0;
        int bad = 0;
        int tap = int'(ctrl_word[9:5]);
        int frac = int'(ctrl_word[4:0]);
        int exp_up = (tap == 31) ? 0 : frac;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (tap != 31 && int'(tap_sel) == tap + 1) up++;
            else if (int'(tap_sel) == tap) base++;
            else bad++;
        end
        chk(up == exp_up && bad == 0, req, up, exp_up);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        range_in = 3'd5;
        repeat (3) @(negedge clk);
        chk(ctrl_word == 10'd512, "R1 word", int'(ctrl_word), 512);
        chk(tap_sel == 5'd16, "R1 tap", int'(tap_sel), 16);
        chk(!word_at_limit && !div_tick, "R1 flags", int'({word_at_limit, div_tick}), 0);
        chk(range_out == 3'd5, "R10 reset", int'(range_out), 5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_word == 10'd512, "R1 after", int'(ctrl_word), 512);
    endtask

    task automatic t_fast();
        mult_n = 10'd100; div_exp = 3'd0;
        rearm();
        send_edges(120, 1);
        chk(ctrl_word == 10'd512, "R5 first edge", int'(ctrl_word), 512);
        send_edges(120, 4);
        chk(ctrl_word == 10'd508, "R2 decrement", int'(ctrl_word), 508);
    endtask

    task automatic t_match();
        mult_n = 10'd50; div_exp = 3'd1;
        rearm();
        send_edges(100, 4);
        chk(ctrl_word == 10'd508, "R4 match D1", int'(ctrl_word), 508);
        mult_n = 10'd100; div_exp = 3'd0;
        rearm();
        send_edges(100, 3);
        chk(ctrl_word == 10'd508, "R4 match D0", int'(ctrl_word), 508);
    endtask

    task automatic t_slow();
        mult_n = 10'd50; div_exp = 3'd1;
        rearm();
        send_edges(80, 6);
        chk(ctrl_word == 10'd513, "R3 increment", int'(ctrl_word), 513);
    endtask

    task automatic t_freeze();
        @(negedge clk) loop_en = 1'b0;
        send_edges(30, 4);
        chk(ctrl_word == 10'd513, "R7 frozen", int'(ctrl_word), 513);
        check_dither("R8 frac 1");
    endtask

    task automatic t_sat_high();
        mult_n = 10'd1000; div_exp = 3'd0;
        rearm();
        send_edges(20, 520);
        chk(ctrl_word == 10'd1023, "R6 top", int'(ctrl_word), 1023);
        chk(word_at_limit, "R6 flag top", int'(word_at_limit), 1);
        check_dither("R8 clamp 31");
    endtask

    task automatic t_sat_low();
        mult_n = 10'd1; div_exp = 3'd0;
        rearm();
        send_edges(20, 1030);
        chk(ctrl_word == 10'd0, "R6 bottom", int'(ctrl_word), 0);
        chk(word_at_limit, "R6 flag bottom", int'(word_at_limit), 1);
        check_dither("R8 tap 0");
    endtask

    task automatic t_half_frac();
        mult_n = 10'd1000; div_exp = 3'd0;
        rearm();
        send_edges(20, 17);
        chk(ctrl_word == 10'd16, "R3 from zero", int'(ctrl_word), 16);
        chk(!word_at_limit, "R6 flag clear", int'(word_at_limit), 0);
        @(negedge clk) loop_en = 1'b0;
        check_dither("R8 frac 16");
    endtask

    task automatic t_divider();
        loop_en = 1'b0;
        for (int d = 0; d < 4; d++) begin
            int ticks = 0;
            @(negedge clk) div_exp = 3'(d);
            repeat (4) @(negedge clk);
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                if (div_tick) ticks++;
            end
            chk(ticks == (64 >> d), "R9 ticks", ticks, 64 >> d);
        end
    endtask

    task automatic t_range();
        for (int v = 0; v < 8; v++) begin
            @(negedge clk) range_in = 3'(v);
            #1;
            chk(range_out == 3'(v), "R10 pass", int'(range_out), v);
        end
    endtask

    initial begin
        t_reset();
        t_fast();
        t_match();
        t_slow();
        t_freeze();
        t_sat_high();
        t_sat_low();
        t_half_frac();
        t_divider();
        t_range();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule